// File: doc/BRIEF.md
# Front-End Configuration Shift Loader

This block programs a serial daisy chain of six front-end readout chips from a local copy of their settings. Each chip holds a 160-bit word made of a 16-bit switch field on top and eighteen 8-bit per-channel DAC values below it. The six words are chained into a single 960-bit image. A host fills the image 16 bits at a time through a simple write port and then issues a start command. The block then drives a slow serial clock and a data line, and pulses a latch strobe after the last bit. While it shifts, it holds an isolation output active so the chips stay disconnected from their sensors. A one-cycle done pulse closes the operation. The shift clock is derived from the system clock with one of two half-period lengths: 20000 or 2000 cycles by default, which gives 1 kHz or 10 kHz from 40 MHz. The rate is picked at start.

A second command performs a short mode update. It shifts only the nine mode bits of each chip into a separate short chain, 54 bits in total, and raises a chain-select output while doing so. The nine mode bits are 4 for shaping time, 4 for gain and 1 for the injection resistor. A calibration-route output steers the calibration pulse to the LED driver (1) or to on-chip charge injection (0). It takes the route requested at start and changes when the done pulse is issued.

During each full load the chain's far-end output is sampled on every rising shift edge and compared on the fly with the stream of the previous full load. A mismatch flag reports any difference. The controller has four states. ST_IDLE goes to ST_SHIFT_LO on an accepted start. ST_SHIFT_LO goes to ST_SHIFT_HI on a half-period tick, which is the rising edge and the echo sample. ST_SHIFT_HI goes back to ST_SHIFT_LO on a tick, or to ST_STROBE after the last bit; this is the falling edge and the next data bit. ST_STROBE returns to ST_IDLE on a tick, ending the latch pulse and issuing done.

Top module: `cfg_shift_loader`

## Requirements
- R1: After reset every output is 0 and the image bank and the echo reference are cleared.
- R2: A write with `wr_en` high while not busy stores `wr_data` into image bits 16w+15..16w, where w is `wr_addr`. Writes while busy, and writes to addresses 60 and above, are ignored. Chip c occupies bits 160c+159..160c. Its switch field is bits 160c+159..160c+144, and DAC channel k is bits 160c+143-8k..160c+136-8k.
- R3: `start_full` in idle shifts all 960 image bits, MSB first: stream bit s is image bit 959-s, so the far chip's top bit goes first and chip 0 ends nearest the input.
- R4: `sdata` changes only where `sclk` falls, or at start with `sclk` low, and is stable where `sclk` rises. Each `sclk` half period lasts HALF_FAST cycles if `rate_fast` was 1 at start, or HALF_SLOW cycles if it was 0. A start-to-done time is (2L+1)·H+1 cycles, where L is the bit count and H the half period.
- R5: `busy` rises the cycle after an accepted start and stays high until the done pulse. `isolate` equals `busy` at all times, and `sclk` is low whenever the block is idle.
- R6: After the last falling edge `latch` goes high for exactly one half period, with `sclk` low. It is pulsed once per load. `done` is then high for one cycle, with `busy` and `isolate` falling at that same edge.
- R7: `start_full` or `start_mode` arriving while busy is ignored. Changes to `rate_fast` and `cal_route` during a load are ignored too.
- R8: `start_mode` in idle, when `start_full` is low, shifts 54 bits with `chain_sel` high for the whole load. For chips 5 down to 0 it sends switch bits 8 down to 0, which are image bits 160c+152..160c+144. Bits 8..5 are shaping, 4..1 gain and 0 the injection resistor. The latch and done sequence is the same as for a full load, and the main chain is not clocked.
- R9: After a full load, `mismatch` is 1 exactly when an earlier full load exists and the `chain_dout` samples differ from that earlier load's stream. The first load gives 0. A mode update leaves `mismatch` and the reference unchanged.
- R10: `cal_sel` takes the `cal_route` value sampled at start and presents it from the done pulse onward, for both load types.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Image word write strobe |
| wr_addr | input | 6 | Image word index |
| wr_data | input | 16 | Image word value |
| start_full | input | 1 | Start a full 960-bit load |
| start_mode | input | 1 | Start a 54-bit mode update |
| rate_fast | input | 1 | 1 selects the short half period, 0 the long one |
| cal_route | input | 1 | Requested calibration route: 1 LED driver, 0 charge injection |
| chain_dout | input | 1 | Far-end output of the main chain |
| sclk | output | 1 | Serial shift clock |
| sdata | output | 1 | Serial data, stable on rising `sclk` |
| latch | output | 1 | Load strobe after the last bit |
| isolate | output | 1 | Holds chips off their sensors during programming |
| chain_sel | output | 1 | 1 while the short mode chain is shifted |
| cal_sel | output | 1 | Calibration route in force |
| busy | output | 1 | A load is running |
| done | output | 1 | One-cycle end-of-load pulse |
| mismatch | output | 1 | Echo differs from the previous full load |

## Verification
`busy` and `isolate` are due at the first sampling point after the start edge. The serial stream is captured at every rising `sclk` rather than at fixed cycle offsets, so data checks do not depend on the divider count. `done` is due exactly (2L+1)·H+1 sampling points after start, and the bench counts sampling points at the falling system-clock edge and compares that count. `mismatch`, `cal_sel` and the modelled chain contents are checked at the done sample, and `done` is checked low again one cycle later.

// File: rtl/cfgsl_pkg.sv
package cfgsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SHIFT_LO = 2'd1,
        ST_SHIFT_HI = 2'd2,
        ST_STROBE   = 2'd3
    } sl_state_t;

    typedef enum logic {
        LD_FULL = 1'b0,
        LD_MODE = 1'b1
    } ld_kind_t;

endpackage

// File: rtl/cfgsl_bank.sv
module cfgsl_bank #(
    parameter int TOTAL_BITS = 960,
    parameter int WORD_BITS  = 16,
    parameter int N_WORDS    = 60,
    parameter int ADDR_W     = 6,
    parameter int IDX_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic              busy,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              commit,
    output logic              img_bit,
    output logic              ref_bit,
    output logic              ref_valid
);

    logic [N_WORDS-1:0][WORD_BITS-1:0] img_q;
    logic [TOTAL_BITS-1:0]             ref_q;
    logic [TOTAL_BITS-1:0]             img_flat;

    assign img_flat = img_q;

    // host image: one word per write, frozen while a load runs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_q <= '0;
        end else if (wr_en && !busy) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (wr_addr == ADDR_W'(w)) begin
                    img_q[w] <= wr_data;
                end
            end
        end
    end

    // reference copy of the last full stream, for the echo compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q     <= '0;
            ref_valid <= 1'b0;
        end else if (commit) begin
            ref_q     <= img_flat;
            ref_valid <= 1'b1;
        end
    end

    assign img_bit = img_flat[rd_idx];
    assign ref_bit = ref_q[rd_idx];

    AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(img_q)); // R2

endmodule

// File: rtl/cfgsl_tick.sv
module cfgsl_tick #(
    parameter int HALF_SLOW = 20000,
    parameter int HALF_FAST = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int HMAX  = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
    localparam int CNT_W = (HMAX > 2) ? $clog2(HMAX) : 1;
    localparam logic [CNT_W-1:0] LIM_S = CNT_W'(HALF_SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_F = CNT_W'(HALF_FAST - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == (fast ? LIM_F : LIM_S));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4

endmodule

// File: rtl/cfgsl_fsm.sv
module cfgsl_fsm
    import cfgsl_pkg::*;
#(
    parameter int N_CHIPS    = 6,
    parameter int CHIP_BITS  = 160,
    parameter int TOTAL_BITS = 960,
    parameter int MODE_BITS  = 9,
    parameter int SW_OFS     = 144,
    parameter int IDX_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_full,
    input  logic             start_mode,
    input  logic             rate_fast,
    input  logic             cal_route,
    input  logic             tick,
    input  logic             img_bit,
    input  logic             ref_bit,
    input  logic             ref_valid,
    input  logic             chain_dout,
    output logic [IDX_W-1:0] rd_idx,
    output logic             commit,
    output logic             rate_q,
    output logic             sclk,
    output logic             sdata,
    output logic             latch,
    output logic             isolate,
    output logic             chain_sel,
    output logic             cal_sel,
    output logic             busy,
    output logic             done,
    output logic             mismatch
);

    localparam int CHIP_W = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1;
    localparam int MB_W   = (MODE_BITS > 1) ? $clog2(MODE_BITS) : 1;
    localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(TOTAL_BITS - 1);
    localparam logic [CHIP_W-1:0] CHIP_TOP = CHIP_W'(N_CHIPS - 1);
    localparam logic [MB_W-1:0]   MB_TOP   = MB_W'(MODE_BITS - 1);

    sl_state_t        state_q, state_d;
    ld_kind_t         kind_q;
    logic [IDX_W-1:0] idx_q;
    logic [CHIP_W-1:0] chip_q;
    logic [MB_W-1:0]  mbit_q;
    logic             last_q, mis_acc_q, route_q;
    logic             go_full, go_mode, use_mode, at_last, echo_bad;

    assign go_full  = start_full;
    assign go_mode  = start_mode && !start_full;
    assign use_mode = (state_q == ST_IDLE) ? go_mode : (kind_q == LD_MODE);
    assign at_last  = (kind_q == LD_MODE) ? ((chip_q == '0) && (mbit_q == '0))
                                          : (idx_q == '0);
    assign rd_idx   = use_mode ? (IDX_W'(chip_q) * IDX_W'(CHIP_BITS) + IDX_W'(SW_OFS)
                                  + IDX_W'(mbit_q))
                               : idx_q;
    assign commit   = (state_q == ST_STROBE) && tick && (kind_q == LD_FULL);
    assign echo_bad = (kind_q == LD_FULL) && ref_valid && (chain_dout != ref_bit);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (go_full || go_mode) state_d = ST_SHIFT_LO;
            ST_SHIFT_LO: if (tick)               state_d = ST_SHIFT_HI;
            ST_SHIFT_HI: if (tick)               state_d = last_q ? ST_STROBE : ST_SHIFT_LO;
            ST_STROBE:   if (tick)               state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= LD_FULL;
            idx_q     <= IDX_TOP;
            chip_q    <= CHIP_TOP;
            mbit_q    <= MB_TOP;
            last_q    <= 1'b0;
            mis_acc_q <= 1'b0;
            route_q   <= 1'b0;
            rate_q    <= 1'b0;
            sclk      <= 1'b0;
            sdata     <= 1'b0;
            latch     <= 1'b0;
            isolate   <= 1'b0;
            chain_sel <= 1'b0;
            cal_sel   <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            mismatch  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go_full || go_mode) begin
                        kind_q    <= go_mode ? LD_MODE : LD_FULL;
                        rate_q    <= rate_fast;
                        route_q   <= cal_route;
                        sdata     <= img_bit;
                        chain_sel <= go_mode;
                        busy      <= 1'b1;
                        isolate   <= 1'b1;
                        mis_acc_q <= 1'b0;
                        last_q    <= 1'b0;
                    end
                end
                ST_SHIFT_LO: begin
                    if (tick) begin
                        sclk <= 1'b1;
                        if (echo_bad) mis_acc_q <= 1'b1;
                        if (at_last) begin
                            last_q <= 1'b1;
                        end else if (kind_q == LD_MODE) begin
                            if (mbit_q == '0) begin
                                mbit_q <= MB_TOP;
                                chip_q <= chip_q - 1'b1;
                            end else begin
                                mbit_q <= mbit_q - 1'b1;
                            end
                        end else begin
                            idx_q <= idx_q - 1'b1;
                        end
                    end
                end
                ST_SHIFT_HI: begin
                    if (tick) begin
                        sclk <= 1'b0;
                        if (last_q) latch <= 1'b1;
                        else        sdata <= img_bit;
                    end
                end
                ST_STROBE: begin
                    if (tick) begin
                        latch     <= 1'b0;
                        done      <= 1'b1;
                        busy      <= 1'b0;
                        isolate   <= 1'b0;
                        chain_sel <= 1'b0;
                        cal_sel   <= route_q;
                        if (kind_q == LD_FULL) mismatch <= mis_acc_q;
                        idx_q     <= IDX_TOP;
                        chip_q    <= CHIP_TOP;
                        mbit_q    <= MB_TOP;
                        last_q    <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_SDATA_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !latch && !isolate && !chain_sel)); // R5
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !isolate && $past(busy))); // R6
    AST_LATCH_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        latch |-> !sclk); // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHIFT_LO || state_q == ST_SHIFT_HI) && (start_full || start_mode))
        |=> ($stable(kind_q) && $stable(route_q) && busy)); // R7

endmodule

// File: rtl/cfg_shift_loader.sv
module cfg_shift_loader #(
    parameter int N_CHIPS   = 6,
    parameter int SW_BITS   = 16,
    parameter int DAC_CH    = 18,
    parameter int DAC_BITS  = 8,
    parameter int MODE_BITS = 9,
    parameter int WORD_BITS = 16,
    parameter int HALF_SLOW = 20000,
    parameter int HALF_FAST = 2000,
    localparam int CHIP_BITS  = SW_BITS + DAC_CH * DAC_BITS,
    localparam int TOTAL_BITS = N_CHIPS * CHIP_BITS,
    localparam int N_WORDS    = TOTAL_BITS / WORD_BITS,
    localparam int ADDR_W     = $clog2(N_WORDS),
    localparam int IDX_W      = $clog2(TOTAL_BITS),
    localparam int SW_OFS     = CHIP_BITS - SW_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_BITS-1:0] wr_data,
    input  logic                 start_full,
    input  logic                 start_mode,
    input  logic                 rate_fast,
    input  logic                 cal_route,
    input  logic                 chain_dout,
    output logic                 sclk,
    output logic                 sdata,
    output logic                 latch,
    output logic                 isolate,
    output logic                 chain_sel,
    output logic                 cal_sel,
    output logic                 busy,
    output logic                 done,
    output logic                 mismatch
);

    logic [IDX_W-1:0] rd_idx;
    logic img_bit, ref_bit, ref_valid, commit, rate_q, tick;

    cfgsl_bank #(
        .TOTAL_BITS(TOTAL_BITS), .WORD_BITS(WORD_BITS), .N_WORDS(N_WORDS),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .rd_idx(rd_idx), .commit(commit),
        .img_bit(img_bit), .ref_bit(ref_bit), .ref_valid(ref_valid)
    );

    cfgsl_tick #(
        .HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .fast(rate_q), .tick(tick)
    );

    cfgsl_fsm #(
        .N_CHIPS(N_CHIPS), .CHIP_BITS(CHIP_BITS), .TOTAL_BITS(TOTAL_BITS),
        .MODE_BITS(MODE_BITS), .SW_OFS(SW_OFS), .IDX_W(IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_full(start_full), .start_mode(start_mode),
        .rate_fast(rate_fast), .cal_route(cal_route), .tick(tick),
        .img_bit(img_bit), .ref_bit(ref_bit), .ref_valid(ref_valid), .chain_dout(chain_dout),
        .rd_idx(rd_idx), .commit(commit), .rate_q(rate_q),
        .sclk(sclk), .sdata(sdata), .latch(latch), .isolate(isolate),
        .chain_sel(chain_sel), .cal_sel(cal_sel), .busy(busy), .done(done),
        .mismatch(mismatch)
    );

    AST_ISOLATE_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> isolate); // R5

endmodule

// File: tb/tb_cfg_shift_loader.sv
module tb_cfg_shift_loader;

    localparam int HS = 6;
    localparam int HF = 3;
    localparam int NB = 960;
    localparam int NM = 54;
    localparam int NW = 60;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, wr_en, start_full, start_mode, rate_fast, cal_route, chain_dout;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic sclk, sdata, latch, isolate, chain_sel, cal_sel, busy, done, mismatch;

    cfg_shift_loader #(.HALF_SLOW(HS), .HALF_FAST(HF)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start_full(start_full), .start_mode(start_mode), .rate_fast(rate_fast),
        .cal_route(cal_route), .chain_dout(chain_dout),
        .sclk(sclk), .sdata(sdata), .latch(latch), .isolate(isolate),
        .chain_sel(chain_sel), .cal_sel(cal_sel), .busy(busy), .done(done),
        .mismatch(mismatch)
    );

    // behavioural chip chains
    logic [NB-1:0] mch;
    logic [NM-1:0] sch;
    assign chain_dout = mch[NB-1];
    always @(posedge sclk) begin
        if (chain_sel) sch <= {sch[NM-2:0], sdata};
        else           mch <= {mch[NB-2:0], sdata};
    end

    bit cap [NB];
    int ncap, nlatch;
    always @(posedge sclk) begin
        if (ncap < NB) cap[ncap] = sdata;
        ncap = ncap + 1;
    end
    always @(posedge latch) nlatch = nlatch + 1;

    int checks = 0, errors = 0;
    logic [NB-1:0] img_m, prev_img;
    bit prev_valid, exp_mis;
    int last_bad;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [NB-1:0] im, input bit md, input int s);
        int c, b;
        if (md) begin
            c = 5 - s / 9;
            b = 8 - s % 9;
            return im[160*c + 144 + b];
        end
        return im[NB-1-s];
    endfunction

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < NW) img_m[a*16 +: 16] = d;
    endtask

    task automatic run_load(input bit md, input bit fast, input bit route, input bit inject);
        int n, bad_iso, bad_sel, L, H, first_bad;
        logic [NB-1:0] mch0;
        logic [NM-1:0] sv;
        L = md ? NM : NB;
        H = fast ? HF : HS;
        ncap = 0; nlatch = 0; bad_iso = 0; bad_sel = 0;
        @(negedge clk);
        mch0 = mch;
        start_full = !md; start_mode = md; rate_fast = fast; cal_route = route;
        @(negedge clk);
        start_full = 1'b0; start_mode = 1'b0; n = 1;
        chk(busy === 1'b1 && isolate === 1'b1, "R5", "busy/isolate after start", busy, 1);
        while (done !== 1'b1 && n < 20000) begin
            if (busy !== isolate) bad_iso++;
            if (busy && chain_sel !== md) bad_sel++;
            if (inject && n == 10) begin
                start_full = 1'b1; start_mode = 1'b1;
                rate_fast = !fast; cal_route = !route;
                wr_en = 1'b1; wr_addr = 6'd0; wr_data = ~img_m[15:0];
            end
            if (inject && n == 11) begin
                start_full = 1'b0; start_mode = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        chk(n == (2*L+1)*H+1, inject ? "R7" : "R4", "cycles start to done", n, (2*L+1)*H+1);
        chk(busy === 1'b0 && isolate === 1'b0, "R6", "busy low at done", busy, 0);
        chk(ncap == L, md ? "R8" : "R3", "rising sclk count", ncap, L);
        first_bad = -1;
        for (int s = 0; s < L && s < NB; s++) begin
            if (first_bad < 0 && cap[s] !== exp_bit(img_m, md, s)) first_bad = s;
        end
        last_bad = first_bad;
        chk(first_bad < 0, md ? "R8" : "R3", "first wrong stream bit", first_bad, -1);
        chk(nlatch == 1, "R6", "latch pulses", nlatch, 1);
        chk(bad_iso == 0, "R5", "cycles isolate != busy", bad_iso, 0);
        chk(bad_sel == 0, "R8", "cycles chain_sel wrong", bad_sel, 0);
        chk(cal_sel === route, "R10", "cal_sel after done", cal_sel, route);
        if (!md) begin
            exp_mis = prev_valid && (mch0 != prev_img);
            prev_img = img_m;
            prev_valid = 1'b1;
            chk(mch === img_m, "R3", "main chain holds image", (mch === img_m), 1);
        end else begin
            for (int s = 0; s < NM; s++) sv[NM-1-s] = exp_bit(img_m, 1'b1, s);
            chk(sch === sv, "R8", "short chain holds mode bits", (sch === sv), 1);
            chk(mch === mch0, "R8", "main chain untouched", (mch === mch0), 1);
        end
        chk(mismatch === exp_mis, "R9", "mismatch flag", mismatch, exp_mis);
        @(negedge clk);
        chk(done === 1'b0, "R6", "done one cycle", done, 0);
    endtask

    initial begin
        #(8 * 190000);
        checks++; errors++;
        $display("FAIL R3 watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        start_full = 1'b0; start_mode = 1'b0; rate_fast = 1'b0; cal_route = 1'b0;
        mch = '0; sch = '0; img_m = '0; prev_img = '0; prev_valid = 1'b0; exp_mis = 1'b0;
        ncap = 0; nlatch = 0; last_bad = -1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({sclk, sdata, latch, isolate, chain_sel, cal_sel, busy, done, mismatch} === 9'b0,
            "R1", "outputs after reset",
            {sclk, sdata, latch, isolate, chain_sel, cal_sel, busy, done, mismatch}, 0);

        // R2 fill the whole image
        for (int w = 0; w < NW; w++) wr(w, 16'($urandom));
        run_load(1'b0, 1'b1, 1'b1, 1'b0);   // first load: no reference
        run_load(1'b0, 1'b0, 1'b0, 1'b1);   // R7 start/rate/route/write during busy
        chk(mch === img_m, "R2", "write while busy ignored", (mch === img_m), 1);

        // out-of-range writes, then corrupt the chain so the echo differs
        wr(60, 16'hFFFF);
        wr(63, 16'hA5A5);
        mch[500] = ~mch[500];
        run_load(1'b0, 1'b1, 1'b0, 1'b0);   // R9 expect mismatch
        chk(last_bad < 0, "R2", "out-of-range writes ignored", last_bad, -1);

        for (int k = 0; k < 8; k++) wr($urandom % NW, 16'($urandom));
        run_load(1'b0, 1'b1, 1'b1, 1'b0);   // R9 compares against previous load

        // R8 mode-bit update
        for (int c = 0; c < 6; c++) wr(10*c + 9, 16'($urandom));
        run_load(1'b1, 1'b1, 1'b0, 1'b0);
        run_load(1'b0, 1'b1, 1'b1, 1'b0);

        // constrained random rounds
        for (int r = 0; r < 5; r++) begin
            int nw;
            nw = $urandom % 6;
            for (int k = 0; k < nw; k++) wr($urandom % NW, 16'($urandom));
            if ($urandom % 3 == 0) mch[$urandom % NB] = ~mch[$urandom % NB];
            run_load(1'($urandom % 2), 1'($urandom % 4 != 0), 1'($urandom % 2), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule